// File: doc/BRIEF.md
# USB Device Bus Suspend and Resume Controller

This block watches the line state of a full-speed USB device and handles its low-power signalling. A sampled bus-idle level and a one-millisecond strobe come in. From them the block raises four sticky interrupt flags: bus suspend, bus wake-up, upstream resume started, and host end-of-resume. Software clears each flag by writing a one to it. A per-flag enable mask selects which flags drive the single interrupt line.

Software may ask for a remote wake-up. The block honours the request only while the suspend flag is up. It then waits for a further stretch of bus silence before it drives resume signalling upstream for a fixed number of milliseconds. A soft-detach bit comes out of reset set, which keeps the pull-up off. Writing it to one and then back to zero makes the host enumerate the device again. A clock-freeze bit is held for the power logic outside the block.

Top module: `usb_lpm_ctrl`

## Requirements
- R1: The suspend flag (flags bit 0) sets on the SUSP_MS-th (default 3rd) millisecond strobe seen while bus_idle has stayed high without a break. It sets at most once per idle stretch and can set again only after bus_idle has been low for at least one cycle.
- R2: The wake-up flag (flags bit 1) sets in every cycle where bus_idle is low and was high in the cycle before, whatever the suspend state.
- R3: When the suspend flag sets, the wake-up flag clears in the same update, and the reverse also holds. A remote wake-up start also clears the suspend flag.
- R4: A pulse on rwk_req is accepted (rwk_pending goes high one cycle later) only if the suspend flag is set in that cycle. Otherwise the pulse is ignored and rwk_pending stays low.
- R5: After acceptance, resume_drive rises and the upstream-resume flag (flags bit 2) sets on the RWK_MS-th (default 5th) strobe that arrives while the bus has stayed idle without a break. A non-idle cycle restarts that count.
- R6: resume_drive stays high for DRV_MS (default 2) strobes. On the last of them, resume_drive and rwk_pending fall together.
- R7: A pulse on host_eor sets the end-of-resume flag (flags bit 3).
- R8: A one in bit i of flag_clr clears flag i unless the flag sets in the same cycle, in which case the set wins. irq is high exactly when some flag is set whose bit in irq_en is also set.
- R9: The detach bit comes out of reset as 1, so pullup_en is 0. pullup_en always equals the inverse of the last value written through detach_we/detach_val. The freeze bit comes out of reset as 0 and follows writes through freeze_we/freeze_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| bus_idle | input | 1 | Sampled bus idle level |
| host_eor | input | 1 | Valid end-of-resume detected from the host |
| rwk_req | input | 1 | Software remote wake-up request strobe |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| irq_en | input | 4 | Interrupt enable mask |
| detach_we | input | 1 | Write strobe for the detach bit |
| detach_val | input | 1 | Value written to the detach bit |
| freeze_we | input | 1 | Write strobe for the clock-freeze bit |
| freeze_val | input | 1 | Value written to the clock-freeze bit |
| flags | output | 4 | Suspend, wake-up, upstream-resume, end-of-resume flags |
| irq | output | 1 | OR of the enabled flags |
| rwk_pending | output | 1 | Remote wake-up request accepted and not yet finished |
| resume_drive | output | 1 | Upstream resume signalling enable to the pads |
| pullup_en | output | 1 | Pull-up enable to the pads |
| clk_frozen | output | 1 | Clock-freeze control bit |

## Verification
All flag, pending, drive, detach and freeze results are registered. Each one is due one clock edge after the cycle whose inputs caused it. irq follows the flags and the current mask with no added delay. The bench drives inputs at the falling edge and updates its reference model on the rising edge that samples them. It then compares every output at the next falling edge, so each check lands in the first cycle the design can show the result. Millisecond strobes come every eighth cycle, which makes the 3, 5 and 2 strobe windows land on exact, predictable edges.

// File: rtl/usb_lpm_pkg.sv
package usb_lpm_pkg;
    localparam int NFLAG = 4;

    typedef enum logic [1:0] {
        FL_SUSP = 2'd0,
        FL_WAKE = 2'd1,
        FL_UPRS = 2'd2,
        FL_EOR  = 2'd3
    } flag_idx_e;

    typedef struct packed {
        logic susp_ev;
        logic wake_ev;
    } line_ev_t;

    typedef struct packed {
        logic start;
        logic pend;
        logic drive;
    } rwk_st_t;

    function automatic int cnt_w(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction
endpackage

// File: rtl/usb_line_timer.sv
module usb_line_timer
    import usb_lpm_pkg::*;
#(
    parameter int SUSP_MS = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ms_tick,
    input  logic     bus_idle,
    output line_ev_t ev
);
    localparam int CW = cnt_w(SUSP_MS);
    localparam logic [CW-1:0] LAST = CW'(SUSP_MS - 1);

    logic [CW-1:0] idle_cnt;
    logic          armed;
    logic          prev_idle;

    always_comb begin
        ev.susp_ev = bus_idle && ms_tick && armed && (idle_cnt == LAST);
        ev.wake_ev = !bus_idle && prev_idle;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt  <= '0;
            armed     <= 1'b1;
            prev_idle <= 1'b1;
        end else begin
            prev_idle <= bus_idle;
            if (!bus_idle) begin
                idle_cnt <= '0;
                armed    <= 1'b1;
            end else begin
                if (ms_tick && idle_cnt != LAST) idle_cnt <= idle_cnt + 1'b1;
                if (ev.susp_ev) armed <= 1'b0;
            end
        end
    end

    assert_susp_needs_idle_R1: assert property (@(posedge clk) disable iff (rst)
        ev.susp_ev |=> !ev.susp_ev);
    assert_wake_after_idle_R2: assert property (@(posedge clk) disable iff (rst)
        ev.wake_ev |-> $past(bus_idle));
endmodule

// File: rtl/usb_rwk_seq.sv
module usb_rwk_seq
    import usb_lpm_pkg::*;
#(
    parameter int RWK_MS = 5,
    parameter int DRV_MS = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    ms_tick,
    input  logic    bus_idle,
    input  logic    susp_flag,
    input  logic    req,
    output rwk_st_t st
);
    localparam int RW = cnt_w(RWK_MS);
    localparam int DW = cnt_w(DRV_MS);
    localparam logic [RW-1:0] RLAST = RW'(RWK_MS - 1);
    localparam logic [DW-1:0] DLAST = DW'(DRV_MS - 1);

    logic [RW-1:0] wait_cnt;
    logic [DW-1:0] drv_cnt;
    logic          pend, drive;

    assign st.pend  = pend;
    assign st.drive = drive;
    assign st.start = pend && !drive && bus_idle && ms_tick && (wait_cnt == RLAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            drive    <= 1'b0;
            wait_cnt <= '0;
            drv_cnt  <= '0;
        end else begin
            if (req && susp_flag && !pend) pend <= 1'b1;
            if (!pend || drive || !bus_idle) wait_cnt <= '0;
            else if (ms_tick && wait_cnt != RLAST) wait_cnt <= wait_cnt + 1'b1;
            if (st.start) begin
                drive   <= 1'b1;
                drv_cnt <= '0;
            end else if (drive && ms_tick) begin
                if (drv_cnt == DLAST) begin
                    drive <= 1'b0;
                    pend  <= 1'b0;
                end else begin
                    drv_cnt <= drv_cnt + 1'b1;
                end
            end
        end
    end

    assert_accept_gated_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(susp_flag) && $past(req));
    assert_drive_in_pending_R5: assert property (@(posedge clk) disable iff (rst)
        drive |-> pend);
    assert_pending_ends_with_drive_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(pend) |-> $fell(drive));
endmodule

// File: rtl/usb_flag_bank.sv
module usb_flag_bank
    import usb_lpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] set,
    input  logic [NFLAG-1:0] hw_clr,
    input  logic [NFLAG-1:0] sw_clr,
    output logic [NFLAG-1:0] q
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)                        q[i] <= 1'b0;
            else if (set[i])                q[i] <= 1'b1;
            else if (hw_clr[i] || sw_clr[i]) q[i] <= 1'b0;
        end

        assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> q[i]);
        assert_clear_takes_R8: assert property (@(posedge clk) disable iff (rst)
            (sw_clr[i] && !set[i]) |=> !q[i]);
    end
endmodule

// File: rtl/usb_lpm_ctrl.sv
module usb_lpm_ctrl
    import usb_lpm_pkg::*;
#(
    parameter int SUSP_MS = 3,
    parameter int RWK_MS  = 5,
    parameter int DRV_MS  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ms_tick,
    input  logic             bus_idle,
    input  logic             host_eor,
    input  logic             rwk_req,
    input  logic [NFLAG-1:0] flag_clr,
    input  logic [NFLAG-1:0] irq_en,
    input  logic             detach_we,
    input  logic             detach_val,
    input  logic             freeze_we,
    input  logic             freeze_val,
    output logic [NFLAG-1:0] flags,
    output logic             irq,
    output logic             rwk_pending,
    output logic             resume_drive,
    output logic             pullup_en,
    output logic             clk_frozen
);
    line_ev_t         lev;
    rwk_st_t          rst_st;
    logic [NFLAG-1:0] set_v, hclr_v;
    logic             detach_q, freeze_q;

    usb_line_timer #(.SUSP_MS(SUSP_MS)) u_line (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .bus_idle(bus_idle), .ev(lev)
    );

    usb_rwk_seq #(.RWK_MS(RWK_MS), .DRV_MS(DRV_MS)) u_rwk (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .bus_idle(bus_idle),
        .susp_flag(flags[FL_SUSP]), .req(rwk_req), .st(rst_st)
    );

    always_comb begin
        set_v           = '0;
        hclr_v          = '0;
        set_v[FL_SUSP]  = lev.susp_ev;
        set_v[FL_WAKE]  = lev.wake_ev;
        set_v[FL_UPRS]  = rst_st.start;
        set_v[FL_EOR]   = host_eor;
        hclr_v[FL_SUSP] = lev.wake_ev || rst_st.start;
        hclr_v[FL_WAKE] = lev.susp_ev;
    end

    usb_flag_bank u_flags (
        .clk(clk), .rst(rst), .set(set_v), .hw_clr(hclr_v), .sw_clr(flag_clr), .q(flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            detach_q <= 1'b1;
            freeze_q <= 1'b0;
        end else begin
            if (detach_we) detach_q <= detach_val;
            if (freeze_we) freeze_q <= freeze_val;
        end
    end

    assign irq          = |(flags & irq_en);
    assign rwk_pending  = rst_st.pend;
    assign resume_drive = rst_st.drive;
    assign pullup_en    = !detach_q;
    assign clk_frozen   = freeze_q;

    assert_no_dual_sw_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FL_SUSP]) |-> !flags[FL_WAKE]);
    assert_wake_kills_susp_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FL_WAKE]) |-> !flags[FL_SUSP]);
    assert_resume_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(resume_drive) |-> flags[FL_UPRS] && !flags[FL_SUSP]);
    assert_eor_sets_R7: assert property (@(posedge clk) disable iff (rst)
        host_eor |=> flags[FL_EOR]);
    assert_pullup_write_R9: assert property (@(posedge clk) disable iff (rst)
        detach_we |=> (pullup_en == !$past(detach_val)));
endmodule

// File: tb/test_usb_lpm_ctrl.sv
`timescale 1ns/1ps
module test_usb_lpm_ctrl;
    localparam int SUSP_MS = 3, RWK_MS = 5, DRV_MS = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic ms_tick = 0, bus_idle = 1, host_eor = 0, rwk_req = 0;
    logic [3:0] flag_clr = '0, irq_en = '0;
    logic detach_we = 0, detach_val = 0, freeze_we = 0, freeze_val = 0;
    logic [3:0] flags;
    logic irq, rwk_pending, resume_drive, pullup_en, clk_frozen;

    always #2.5 clk = ~clk;

    usb_lpm_ctrl #(.SUSP_MS(SUSP_MS), .RWK_MS(RWK_MS), .DRV_MS(DRV_MS)) i_usb_lpm_ctrl (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .bus_idle(bus_idle), .host_eor(host_eor),
        .rwk_req(rwk_req), .flag_clr(flag_clr), .irq_en(irq_en), .detach_we(detach_we),
        .detach_val(detach_val), .freeze_we(freeze_we), .freeze_val(freeze_val),
        .flags(flags), .irq(irq), .rwk_pending(rwk_pending), .resume_drive(resume_drive),
        .pullup_en(pullup_en), .clk_frozen(clk_frozen)
    );

    int n_chk = 0, n_fail = 0, div = 0;
    bit done = 0;
    int seen_susp = 0, seen_drive = 0, seen_ignored = 0;

    // reference state
    logic [3:0] m_flags = '0;
    int  m_idle = 0, m_wait = 0, m_dcnt = 0;
    bit  m_armed = 1, m_prev = 1, m_pend = 0, m_drive = 0, m_det = 1, m_frz = 0;

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic bit any_en(input logic [3:0] f, input logic [3:0] e);
        return |(f & e);
    endfunction

    task automatic model_step();
        bit sev, wev, acc, start, dend;
        sev   = bus_idle && ms_tick && m_armed && (m_idle == SUSP_MS - 1);
        wev   = !bus_idle && m_prev;
        acc   = rwk_req && m_flags[0] && !m_pend;
        start = m_pend && !m_drive && bus_idle && ms_tick && (m_wait == RWK_MS - 1);
        dend  = m_drive && ms_tick && (m_dcnt == DRV_MS - 1);
        if (rwk_req && !m_flags[0]) seen_ignored++;
        // flags
        if (sev) m_flags[0] = 1; else if (wev || start || flag_clr[0]) m_flags[0] = 0;
        if (wev) m_flags[1] = 1; else if (sev || flag_clr[1]) m_flags[1] = 0;
        if (start) m_flags[2] = 1; else if (flag_clr[2]) m_flags[2] = 0;
        if (host_eor) m_flags[3] = 1; else if (flag_clr[3]) m_flags[3] = 0;
        // idle timer
        if (!bus_idle) begin m_idle = 0; m_armed = 1; end
        else begin
            if (ms_tick && m_idle != SUSP_MS - 1) m_idle++;
            if (sev) m_armed = 0;
        end
        // remote wake
        if (!m_pend || m_drive || !bus_idle) m_wait = 0;
        else if (ms_tick && m_wait != RWK_MS - 1) m_wait++;
        if (start) begin m_drive = 1; m_dcnt = 0; seen_drive++; end
        else if (m_drive && ms_tick) begin
            if (dend) begin m_drive = 0; m_pend = 0; end else m_dcnt++;
        end
        if (acc) m_pend = 1;
        m_prev = bus_idle;
        if (sev) seen_susp++;
        if (detach_we) m_det = detach_val;
        if (freeze_we) m_frz = freeze_val;
    endtask

    task automatic compare();
        chk("R1 suspend flag", flags[0], m_flags[0]);
        chk("R2/R3 wake flag", flags[1], m_flags[1]);
        chk("R5 upstream-resume flag", flags[2], m_flags[2]);
        chk("R7 end-of-resume flag", flags[3], m_flags[3]);
        chk("R8 irq", irq, any_en(m_flags, irq_en));
        chk("R4 rwk_pending", rwk_pending, m_pend);
        chk("R6 resume_drive", resume_drive, m_drive);
        chk("R9 pullup_en", pullup_en, !m_det);
        chk("R9 clk_frozen", clk_frozen, m_frz);
    endtask

    // inputs set at negedge by caller; strobe generated here
    task automatic step();
        ms_tick = (div == 7);
        div = (div + 1) % 8;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        host_eor = 0; rwk_req = 0; flag_clr = '0; detach_we = 0; freeze_we = 0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state (R9, flags clear)
        chk("R9 reset pullup off", pullup_en, 0);
        chk("R9 reset freeze", clk_frozen, 0);
        chk("R8 reset flags", flags, 0);
        chk("R4 reset pending", rwk_pending, 0);

        // R4: early request ignored, bus idle, no suspend yet
        irq_en = 4'hF;
        rwk_req = 1;
        step();
        chk("R4 early request ignored", rwk_pending, 0);

        // R1/R5/R6 directed: long idle, request after suspend
        for (int i = 0; i < 40; i++) step();
        chk("R1 suspend after idle", flags[0], 1);
        rwk_req = 1;
        step();
        chk("R4 accepted after suspend", rwk_pending, 1);
        for (int i = 0; i < 120; i++) step();
        chk("R6 pending cleared after drive", rwk_pending, 0);
        chk("R5 upstream flag set", flags[2], 1);
        chk("R3 suspend cleared by resume", flags[0], 0);

        // R2: wake from non-idle
        bus_idle = 0;
        step();
        chk("R2 wake on activity", flags[1], 1);

        // R9: detach toggle
        detach_we = 1; detach_val = 1; step();
        chk("R9 detach set", pullup_en, 0);
        detach_we = 1; detach_val = 0; step();
        chk("R9 detach cleared", pullup_en, 1);

        // random phase
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(0, 40) == 0) bus_idle = ~bus_idle;
            if ($urandom_range(0, 3) == 0 && !bus_idle) bus_idle = ($urandom_range(0, 6) != 0);
            rwk_req  = ($urandom_range(0, 30) == 0);
            host_eor = ($urandom_range(0, 60) == 0);
            if ($urandom_range(0, 8) == 0) flag_clr = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 100) == 0) irq_en = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 80) == 0) begin detach_we = 1; detach_val = 1'($urandom_range(0, 1)); end
            if ($urandom_range(0, 80) == 0) begin freeze_we = 1; freeze_val = 1'($urandom_range(0, 1)); end
            if (n % 1500 == 0) bus_idle = 1;
            step();
        end
        chk("R1 suspend events occurred", int'(seen_susp > 2), 1);
        chk("R5 resume sequences occurred", int'(seen_drive > 0), 1);
        chk("R4 ignored requests occurred", int'(seen_ignored > 0), 1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got 0 expected 1 (run ended)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule